// File: doc/BRIEF.md
# Prescaled Wide Binary Counter with Pipelined Group Enable

This block is a wide synchronous binary up-counter, 24 bits by default, split into 3-bit groups that all share one clock. The lowest group counts on every enabled clock and acts as a divide-by-8 prescaler for everything above it. Its carry towards the upper groups is not decoded from the current count. It is registered one cycle early, on the state 6, so that it is already a clean flop output during the cycle in which the group holds 7.

The upper groups pass their enable along a series AND chain, one group to the next. That chain is only used on one enabled cycle in eight. It therefore has the seven cycles in between to settle, without any change to the clock rate.

Three count-enable inputs are ANDed into one internal count enable. Dropping any of them freezes the whole count together with the registered prescaler carry. The final group's carry is brought out so that counters can be cascaded.

Top module: `wide_presc_counter`

## Requirements
- R1: The count advances on a rising clock edge only when all three enables (`en_a_i`, `en_b_i`, `en_c_i`) are 1; if any of them is 0 at that edge, `count_o` keeps its value.
- R2: The lowest group (`count_o[2:0]`) steps by one modulo 8 on every enabled edge, with bit 0 toggling, bit 1 toggling when bit 0 is 1, and bit 2 toggling when bits 0 and 1 are both 1.
- R3: `carry_o` is 1 exactly when all three enables are 1 and every bit of `count_o` is 1, and is 0 otherwise.
- R4: The lowest group's carry to the upper groups is a register loaded on an enabled edge with (group == 6), so it is 1 exactly while the group holds 7; the upper groups advance only on an enabled edge during such a cycle.
- R5: Group k above the lowest (bits 3k+2 down to 3k) advances by one on an enabled edge exactly when every bit below bit 3k is 1, its enable passing through a series chain from group to group.
- R6: Across the whole width, `count_o` increases by one per enabled edge and wraps from all ones to zero.
- R7: While the count enable is off, the registered low-group carry also holds, so that after a freeze at any low-group value (including 6 and 7) counting resumes with no skipped or repeated value.
- R8: A rising edge with `rst_n` at 0 clears `count_o` and the registered carry. The reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all groups |
| rst_n | input | 1 | Synchronous active-low reset |
| en_a_i | input | 1 | Count enable, first term |
| en_b_i | input | 1 | Count enable, second term |
| en_c_i | input | 1 | Count enable, third term |
| count_o | output | 3*NUM_GROUPS | Counter value |
| carry_o | output | 1 | High while enabled and the count is all ones |

## Verification
The assertions take for granted that the three enables are synchronous to `clk` and stable around each rising edge. They also assume that reset is held for at least one edge before counting, so that the pipelined carry register starts consistent with the low group. The stimulus changes every input 1 ns after a rising edge and starts with two reset edges. Reset asserted in the middle of a run arrives the same way. A 9-bit instance runs beside the 24-bit one so that all-ones, `carry_o` and the wrap occur many times within the run.

// File: rtl/presc_cnt_pkg.sv
// Shared constants and helpers for the prescaled wide counter.
// Assumes every group is 3 bits wide; the toggle rule is a plain binary increment.
package presc_cnt_pkg;
    localparam int GRP_W = 3;
    typedef logic [GRP_W-1:0] grp_t;

    // Per-bit toggle mask: bit i flips when enabled and all lower bits are 1.
    function automatic grp_t toggle_mask(grp_t q, logic en);
        grp_t m;
        m[0] = en;
        for (int i = 1; i < GRP_W; i++) begin
            m[i] = m[i-1] & q[i-1];
        end
        return m;
    endfunction
endpackage

// File: rtl/presc_low_stage.sv
// Lowest 3-bit group: counts on every enabled clock and acts as a divide-by-8 prescaler.
// Its carry is pipelined. The register loads (q == 6) on an enabled edge, so it is high while q == 7.
// Assumes reset is applied before counting so that the carry register matches q.
module presc_low_stage
    import presc_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output grp_t q_o,
    output logic carry_o
);
    localparam grp_t ALL_ONES  = '1;
    localparam grp_t PRE_WRAP  = ALL_ONES - grp_t'(1);

    grp_t q;
    logic carry_q;

    // Count register: toggle bits per the carry-lookahead rule inside the group.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q ^ toggle_mask(q, en_i);
    end

    // Pipelined carry: predicts the all-ones state one edge ahead, holds while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)    carry_q <= 1'b0;
        else if (en_i) carry_q <= (q == PRE_WRAP);
    end

    assign q_o     = q;
    assign carry_o = en_i & carry_q;

    assert_carry_tracks_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q == (q == ALL_ONES));
    assert_low_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> q == grp_t'($past(q) + grp_t'(1)));
    assert_low_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(q) && $stable(carry_q));
endmodule

// File: rtl/presc_upper_group.sv
// One upper 3-bit group in the series enable chain.
// Advances when its chained enable is high; passes the enable on when it holds all ones.
// Assumes cin_i comes from registered logic at most one chain away; it has multicycle slack.
module presc_upper_group
    import presc_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cin_i,
    output grp_t q_o,
    output logic cout_o
);
    grp_t q;

    // Count register for this group.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q ^ toggle_mask(q, cin_i);
    end

    assign q_o    = q;
    assign cout_o = cin_i & (&q);

    assert_upper_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cin_i |=> q == grp_t'($past(q) + grp_t'(1)));
    assert_upper_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cin_i |=> $stable(q));
endmodule

// File: rtl/wide_presc_counter.sv
// Wide binary counter built from 3-bit groups on one clock.
// Group 0 is a divide-by-8 prescaler with a pipelined carry. Groups above chain their enables in series.
// Assumes NUM_GROUPS >= 2 and enables that are synchronous to clk.
module wide_presc_counter
    import presc_cnt_pkg::*;
#(
    parameter int NUM_GROUPS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_a_i,
    input  logic                        en_b_i,
    input  logic                        en_c_i,
    output logic [NUM_GROUPS*GRP_W-1:0] count_o,
    output logic                        carry_o
);
    localparam int WIDTH = NUM_GROUPS * GRP_W;

    logic                  cnt_en;
    logic [NUM_GROUPS-1:0] chain;

    // Combined count enable.
    assign cnt_en = en_a_i & en_b_i & en_c_i;

    presc_low_stage u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cnt_en),
        .q_o     (count_o[GRP_W-1:0]),
        .carry_o (chain[0])
    );

    // Upper groups: each group's enable is the previous group's carry.
    for (genvar k = 1; k < NUM_GROUPS; k++) begin : g_upper
        presc_upper_group u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .cin_i  (chain[k-1]),
            .q_o    (count_o[k*GRP_W +: GRP_W]),
            .cout_o (chain[k])
        );
    end

    assign carry_o = chain[NUM_GROUPS-1];

    assert_carry_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (cnt_en && (&count_o)));
    assert_full_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> count_o == WIDTH'($past(count_o) + WIDTH'(1)));
    assert_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count_o));
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> count_o == '0);
endmodule

// File: tb/test_wide_presc_counter.sv
// Scoreboard bench: the driver pushes the outputs expected in each cycle, and the monitor compares them at the falling edge.
module test_wide_presc_counter;
    localparam int BIG_W = 24;
    localparam int SML_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
    logic [BIG_W-1:0] cnt_big;
    logic [SML_W-1:0] cnt_sml;
    logic car_big, car_sml;

    always #5 clk = ~clk;

    wide_presc_counter i_wide_presc_counter (
        .clk(clk), .rst_n(rst_n), .en_a_i(en_a), .en_b_i(en_b), .en_c_i(en_c),
        .count_o(cnt_big), .carry_o(car_big));

    wide_presc_counter #(.NUM_GROUPS(3)) i_wide_presc_counter_small (
        .clk(clk), .rst_n(rst_n), .en_a_i(en_a), .en_b_i(en_b), .en_c_i(en_c),
        .count_o(cnt_sml), .carry_o(car_sml));

    typedef struct {
        logic [BIG_W-1:0] big;
        logic [SML_W-1:0] sml;
        logic             cb;
        logic             cs;
        string            tag;
    } item_t;

    item_t sb_q[$];
    logic [BIG_W-1:0] ref_big = '0;
    logic [SML_W-1:0] ref_sml = '0;
    int vectors = 0;
    int miscompares = 0;

    // Driver: apply inputs just after a rising edge and record what this cycle must show.
    task automatic step(input logic r, input logic a, input logic b, input logic c, input string tag);
        item_t it;
        logic g;
        @(posedge clk);
        #1;
        rst_n = r; en_a = a; en_b = b; en_c = c;
        g = a & b & c;
        it.big = ref_big;
        it.sml = ref_sml;
        it.cb  = g & (&ref_big);
        it.cs  = g & (&ref_sml);
        it.tag = tag;
        sb_q.push_back(it);
        if (!r) begin
            ref_big = '0;
            ref_sml = '0;
        end else if (g) begin
            ref_big = ref_big + 1'b1;
            ref_sml = ref_sml + 1'b1;
        end
    endtask

    task automatic run(input int n, input logic a, input logic b, input logic c, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, a, b, c, tag);
    endtask

    // Monitor: pop one expected item per cycle and compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                vectors++;
                if (cnt_big !== it.big) begin
                    miscompares++;
                    $display("FAIL %s wide count actual=%h expected=%h", it.tag, cnt_big, it.big);
                end
                if (cnt_sml !== it.sml) begin
                    miscompares++;
                    $display("FAIL %s small count actual=%h expected=%h", it.tag, cnt_sml, it.sml);
                end
                if (car_big !== it.cb) begin
                    miscompares++;
                    $display("FAIL %s/R3 wide carry actual=%b expected=%b", it.tag, car_big, it.cb);
                end
                if (car_sml !== it.cs) begin
                    miscompares++;
                    $display("FAIL %s/R3 small carry actual=%b expected=%b", it.tag, car_sml, it.cs);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        miscompares++;
        $display("FAIL watchdog (R1..all) actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        // R8: reset state, enables present but reset held
        step(1'b0, 1'b1, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        // R2 / R4: first counts through the low group and into group 1
        run(20, 1'b1, 1'b1, 1'b1, "R2");
        // R1: each single enable low holds the count
        run(4, 1'b0, 1'b1, 1'b1, "R1");
        run(4, 1'b1, 1'b0, 1'b1, "R1");
        run(4, 1'b1, 1'b1, 1'b0, "R1");
        run(3, 1'b0, 1'b0, 1'b0, "R1");
        // R7: freeze while the low group holds 6, then resume
        while (ref_big[2:0] != 3'd6) step(1'b1, 1'b1, 1'b1, 1'b1, "R4");
        run(3, 1'b0, 1'b1, 1'b1, "R7");
        run(4, 1'b1, 1'b1, 1'b1, "R7");
        // R7: freeze while the low group holds 7, then resume
        while (ref_big[2:0] != 3'd7) step(1'b1, 1'b1, 1'b1, 1'b1, "R4");
        run(3, 1'b1, 1'b0, 1'b1, "R7");
        run(4, 1'b1, 1'b1, 1'b1, "R7");
        // R5 / R6: long run ripples up the wide counter and wraps the small one
        run(5000, 1'b1, 1'b1, 1'b1, "R6");
        // R1 / R5: alternate enable every cycle across carries
        for (int i = 0; i < 2000; i++) step(1'b1, 1'b1, 1'b1, i[0], "R5");
        // R8: reset in the middle of a run, then recount
        step(1'b0, 1'b1, 1'b1, 1'b1, "R8");
        run(600, 1'b1, 1'b1, 1'b1, "R6");
        @(negedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule